// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the path a local microprocessor uses to reach a bank of internal 8-bit registers. It does this through a single index register. The index holds the address of the target register. It can be loaded in one of two ways. The first is a capture from the multiplexed address/data bus on the falling edge of an address-latch strobe, taken from one of two selectable strobe inputs. The second is a plain write to the index itself. A register-select input decides whether a bus access touches the index or the register the index points at.

Every data access through the index is followed by an increment of the low four index bits, so the processor can walk a 16-register page without reloading the address. Address 00h is exempt from the increment, so a stream of reads or writes at 00h keeps hitting the same location. That location is typically a FIFO port. All bus inputs are treated as synchronous to `clk` and are edge-detected inside the block. The register bank sits outside the block and sees an address, a one-cycle write pulse with data, a one-cycle read pulse, and a combinational read-data return.

Top module: `iap_port`

## Requirements
- R1: After synchronous reset, `bank_addr` is 00h, `bus_dout` is 00h, and `bank_wr_en` and `bank_rd_en` are low.
- R2: With `cfg_latch_mode` low and `reg_sel` low, a write cycle on `cpu_wr` loads `bus_din` into the index, which appears on `bank_addr` after the strobe's trailing edge.
- R3: A read cycle with `reg_sel` low returns the current index on `bus_dout` and leaves the index unchanged.
- R4: A write cycle with `reg_sel` high produces exactly one cycle of `bank_wr_en`, with `bank_wdata` equal to `bus_din` and `bank_addr` still holding the index from before the access.
- R5: A read cycle with `reg_sel` high places `bank_rdata` at the index in effect at the strobe's leading edge onto `bus_dout`, and pulses `bank_rd_en` for one cycle.
- R6: On the trailing edge of a data access (`reg_sel` high at the leading edge), the low 4 index bits increment modulo 16 and the upper 4 bits are kept. For example, 3Fh becomes 30h.
- R7: A data access while the index is 00h leaves the index at 00h.
- R8: With `cfg_latch_mode` high, the falling edge of `ale_a` loads `bus_din` into the index when `cfg_strobe_sel` is 0, and the falling edge of `ale_b` does so when it is 1. The unselected strobe has no effect.
- R9: With `cfg_latch_mode` high, a write cycle with `reg_sel` low leaves the index unchanged.
- R10: When a latch capture and the trailing edge of a data access fall on the same clock, the captured value wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_latch_mode | input | 1 | 1: index loaded only from address-latch strobes |
| cfg_strobe_sel | input | 1 | 0: use `ale_a`, 1: use `ale_b` for capture |
| ale_a | input | 1 | Address-latch strobe A (falling edge captures) |
| ale_b | input | 1 | Address-latch strobe B (falling edge captures) |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| reg_sel | input | 1 | 0: index register, 1: register addressed by index |
| bus_din | input | W | Multiplexed address/data from processor |
| bus_dout | output | W | Registered read data to processor |
| bank_addr | output | W | Current index, address toward register bank |
| bank_wr_en | output | 1 | One-cycle write pulse toward register bank |
| bank_wdata | output | W | Write data toward register bank |
| bank_rd_en | output | 1 | One-cycle read pulse toward register bank |
| bank_rdata | input | W | Read data from register bank at `bank_addr` |

## Verification
The hardest case to reach is a latch capture that lands on the same clock as the trailing edge of a data access. Only then do the increment and the capture compete for the index. The stimulus sets up this case by raising `ale_b` together with a data write strobe, then dropping both on the same falling clock with the new address already on the bus. The bench then checks that the index equals the captured address rather than the incremented one, and that the write still went to the old address. The wrap from xFh to x0h and the exemption at 00h are reached by placing the index at those values before a data access.

// File: rtl/iap_pkg.sv
package iap_pkg;
  // edge events of the processor read/write strobes
  typedef struct packed {
    logic rd_rise;
    logic rd_fall;
    logic wr_rise;
    logic wr_fall;
  } bus_ev_t;

  // falling edges of the two address-latch strobes
  typedef struct packed {
    logic a_fall;
    logic b_fall;
  } ale_ev_t;
endpackage

// File: rtl/iap_edge.sv
module iap_edge
  import iap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cpu_rd,
  input  logic    cpu_wr,
  input  logic    ale_a,
  input  logic    ale_b,
  output bus_ev_t bus_ev,
  output ale_ev_t ale_ev
);
  localparam int N = 4;

  logic [N-1:0] cur;
  logic [N-1:0] prev;
  logic [N-1:0] rise;
  logic [N-1:0] fall;

  assign cur = {ale_b, ale_a, cpu_wr, cpu_rd};

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = cur[g] & ~prev[g];
    assign fall[g] = ~cur[g] & prev[g];
  end

  assign bus_ev.rd_rise = rise[0];
  assign bus_ev.rd_fall = fall[0];
  assign bus_ev.wr_rise = rise[1];
  assign bus_ev.wr_fall = fall[1];
  assign ale_ev.a_fall  = fall[2];
  assign ale_ev.b_fall  = fall[3];

  logic unused_rise;
  assign unused_rise = ^rise[3:2];
endmodule

// File: rtl/iap_access.sv
module iap_access
  import iap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  bus_ev_t      bus_ev,
  input  logic         reg_sel,
  input  logic         latch_mode,
  input  logic [W-1:0] bus_din,
  input  logic [W-1:0] idx,
  input  logic [W-1:0] bank_rdata,
  output logic         bank_rd_en,
  output logic         bank_wr_en,
  output logic [W-1:0] bank_wdata,
  output logic [W-1:0] bus_dout,
  output logic         idx_wr,
  output logic         acc_done
);
  logic sel_q;
  logic lead;

  assign lead     = bus_ev.rd_rise | bus_ev.wr_rise;
  assign idx_wr   = bus_ev.wr_rise & ~reg_sel & ~latch_mode;
  assign acc_done = (bus_ev.rd_fall | bus_ev.wr_fall) & sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b0;
      bank_rd_en <= 1'b0;
      bank_wr_en <= 1'b0;
      bank_wdata <= '0;
      bus_dout   <= '0;
    end else begin
      if (lead) sel_q <= reg_sel;
      bank_wr_en <= bus_ev.wr_rise & reg_sel;
      bank_rd_en <= bus_ev.rd_rise & reg_sel;
      if (bus_ev.wr_rise & reg_sel) bank_wdata <= bus_din;
      if (bus_ev.rd_rise) bus_dout <= reg_sel ? bank_rdata : idx;
    end
  end

  // R4: bank write strobe lasts a single cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
    bank_wr_en |=> !bank_wr_en);
  // R5: bank read strobe lasts a single cycle
  a_r5_rd_single: assert property (@(posedge clk) disable iff (rst)
    bank_rd_en |=> !bank_rd_en);
endmodule

// File: rtl/iap_index.sv
module iap_index
  import iap_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          INC_W     = 4,
  parameter logic [W-1:0] HOLD_ADDR = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         latch_mode,
  input  logic         strobe_sel,
  input  ale_ev_t      ale_ev,
  input  logic [W-1:0] bus_din,
  input  logic         idx_wr,
  input  logic         acc_done,
  output logic [W-1:0] idx
);
  localparam int UP_W = W - INC_W;

  logic             latch_ld;
  logic             bump;
  logic [INC_W-1:0] low_next;

  assign latch_ld = latch_mode & (strobe_sel ? ale_ev.b_fall : ale_ev.a_fall);
  assign bump     = acc_done & (idx != HOLD_ADDR);
  assign low_next = idx[INC_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)           idx <= '0;
    else if (latch_ld) idx <= bus_din;
    else if (idx_wr)   idx <= bus_din;
    else if (bump)     idx <= {idx[W-1:INC_W], low_next};
  end

  // R8 / R10: a strobe capture always lands, even against an increment
  a_r10_latch_wins: assert property (@(posedge clk) disable iff (rst)
    latch_ld |=> idx == $past(bus_din));
  // R2: direct write loads the bus value
  a_r2_direct_load: assert property (@(posedge clk) disable iff (rst)
    idx_wr && !latch_ld |=> idx == $past(bus_din));
  // R6: low bits step by one, upper bits kept
  a_r6_low_step: assert property (@(posedge clk) disable iff (rst)
    acc_done && !latch_ld && !idx_wr && idx != HOLD_ADDR |=>
      idx[INC_W-1:0] == INC_W'($past(idx[INC_W-1:0]) + 1'b1) &&
      idx[W-1:INC_W] == $past(idx[W-1:INC_W]));
  // R7: hold address is never stepped away from
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (rst)
    acc_done && !latch_ld && !idx_wr && idx == HOLD_ADDR |=> idx == HOLD_ADDR);

  logic [UP_W-1:0] unused_up;
  assign unused_up = '0;
endmodule

// File: rtl/iap_port.sv
module iap_port
  import iap_pkg::*;
#(
  parameter int           W         = 8,
  parameter int           INC_W     = 4,
  parameter logic [W-1:0] HOLD_ADDR = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_latch_mode,
  input  logic         cfg_strobe_sel,
  input  logic         ale_a,
  input  logic         ale_b,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] bus_din,
  output logic [W-1:0] bus_dout,
  output logic [W-1:0] bank_addr,
  output logic         bank_wr_en,
  output logic [W-1:0] bank_wdata,
  output logic         bank_rd_en,
  input  logic [W-1:0] bank_rdata
);
  bus_ev_t      bus_ev;
  ale_ev_t      ale_ev;
  logic         idx_wr;
  logic         acc_done;
  logic [W-1:0] idx;

  iap_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .cpu_rd (cpu_rd),
    .cpu_wr (cpu_wr),
    .ale_a  (ale_a),
    .ale_b  (ale_b),
    .bus_ev (bus_ev),
    .ale_ev (ale_ev)
  );

  iap_access #(.W(W)) u_access (
    .clk        (clk),
    .rst        (rst),
    .bus_ev     (bus_ev),
    .reg_sel    (reg_sel),
    .latch_mode (cfg_latch_mode),
    .bus_din    (bus_din),
    .idx        (idx),
    .bank_rdata (bank_rdata),
    .bank_rd_en (bank_rd_en),
    .bank_wr_en (bank_wr_en),
    .bank_wdata (bank_wdata),
    .bus_dout   (bus_dout),
    .idx_wr     (idx_wr),
    .acc_done   (acc_done)
  );

  iap_index #(.W(W), .INC_W(INC_W), .HOLD_ADDR(HOLD_ADDR)) u_index (
    .clk        (clk),
    .rst        (rst),
    .latch_mode (cfg_latch_mode),
    .strobe_sel (cfg_strobe_sel),
    .ale_ev     (ale_ev),
    .bus_din    (bus_din),
    .idx_wr     (idx_wr),
    .acc_done   (acc_done),
    .idx        (idx)
  );

  assign bank_addr = idx;
endmodule

// File: tb/sim_iap_port.sv
module sim_iap_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_latch_mode = 1'b0, cfg_strobe_sel = 1'b0;
  logic       ale_a = 1'b0, ale_b = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout, bank_addr, bank_wdata, bank_rdata;
  logic       bank_wr_en, bank_rd_en;
  logic [7:0] mem [256];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iap_port u0 (
    .clk(clk), .rst(rst), .cfg_latch_mode(cfg_latch_mode), .cfg_strobe_sel(cfg_strobe_sel),
    .ale_a(ale_a), .ale_b(ale_b), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .reg_sel(reg_sel),
    .bus_din(bus_din), .bus_dout(bus_dout), .bank_addr(bank_addr), .bank_wr_en(bank_wr_en),
    .bank_wdata(bank_wdata), .bank_rd_en(bank_rd_en), .bank_rdata(bank_rdata)
  );

  always @(posedge clk) if (bank_wr_en) mem[bank_addr] <= bank_wdata;
  assign bank_rdata = mem[bank_addr];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one strobe cycle, sampled two falling clocks after the leading edge
  task automatic cyc(input logic wr, input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; bus_din = d;
    if (wr) cpu_wr = 1'b1; else cpu_rd = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; cpu_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic ale_pulse(input logic use_b, input logic [7:0] d);
    @(negedge clk); bus_din = d;
    if (use_b) ale_b = 1'b1; else ale_a = 1'b1;
    @(negedge clk); ale_a = 1'b0; ale_b = 1'b0;
    @(negedge clk);
  endtask

  // {op, din, expected dout, expected addr after}; op 0 idx write, 1 data write, 2 data read, 3 idx read
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h10, 8'h00, 8'h10}, {2'd1, 8'hA5, 8'h00, 8'h11},
    {2'd1, 8'h5A, 8'h00, 8'h12}, {2'd0, 8'h10, 8'h00, 8'h10},
    {2'd2, 8'h00, 8'hA5, 8'h11}, {2'd2, 8'h00, 8'h5A, 8'h12},
    {2'd3, 8'h00, 8'h12, 8'h12}, {2'd0, 8'h3F, 8'h00, 8'h3F},
    {2'd1, 8'h77, 8'h00, 8'h30}, {2'd0, 8'h3F, 8'h00, 8'h3F},
    {2'd2, 8'h00, 8'h77, 8'h30}, {2'd0, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'hC3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'hC3, 8'h00},
    {2'd2, 8'h00, 8'hC3, 8'h00}, {2'd0, 8'hEE, 8'h00, 8'hEE},
    {2'd1, 8'h01, 8'h00, 8'hEF}, {2'd1, 8'h02, 8'h00, 8'hE0}
  };

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr", bank_addr, 8'h00);
    chk("R1 dout", bus_dout, 8'h00);
    chk("R1 strobes", {6'd0, bank_wr_en, bank_rd_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] d, ed, ea;
      {op, d, ed, ea} = VEC[i];
      case (op)
        2'd0: begin cyc(1'b1, 1'b0, d); chk("R2 idx write", bank_addr, ea); end
        2'd1: begin cyc(1'b1, 1'b1, d); chk("R6 step after write", bank_addr, ea); end
        2'd2: begin cyc(1'b0, 1'b1, d); chk("R5 data read", bus_dout, ed);
                    chk("R6 step after read", bank_addr, ea); end
        default: begin cyc(1'b0, 1'b0, d); chk("R3 idx read", bus_dout, ed);
                       chk("R3 no step", bank_addr, ea); end
      endcase
    end

    // R7: repeated data access at 00h stays at 00h
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R7 hold at 00", bank_addr, 8'h00);

    // R4: write pulse shape with old address
    cyc(1'b1, 1'b0, 8'h24);
    @(negedge clk); reg_sel = 1'b1; bus_din = 8'h9C; cpu_wr = 1'b1;
    @(negedge clk);
    chk("R4 wr_en", {7'd0, bank_wr_en}, 8'h01);
    chk("R4 addr old", bank_addr, 8'h24);
    chk("R4 wdata", bank_wdata, 8'h9C);
    @(negedge clk);
    chk("R4 wr_en single", {7'd0, bank_wr_en}, 8'h00);
    cpu_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4 addr after", bank_addr, 8'h25);
    cyc(1'b1, 1'b0, 8'h24);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R4 stored", bus_dout, 8'h9C);

    // R8: selectable strobes
    cfg_latch_mode = 1'b1; cfg_strobe_sel = 1'b0;
    ale_pulse(1'b0, 8'h45);
    chk("R8 strobe A", bank_addr, 8'h45);
    ale_pulse(1'b1, 8'h99);
    chk("R8 B ignored", bank_addr, 8'h45);
    cfg_strobe_sel = 1'b1;
    ale_pulse(1'b1, 8'h67);
    chk("R8 strobe B", bank_addr, 8'h67);
    ale_pulse(1'b0, 8'h11);
    chk("R8 A ignored", bank_addr, 8'h67);

    // R9: direct write ignored in latch mode
    cyc(1'b1, 1'b0, 8'h22);
    chk("R9 direct ignored", bank_addr, 8'h67);

    // R10: capture coincides with trailing edge of a data write
    @(negedge clk); reg_sel = 1'b1; bus_din = 8'hAA; cpu_wr = 1'b1; ale_b = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; ale_b = 1'b0; bus_din = 8'h5B;
    @(negedge clk);
    chk("R10 capture wins", bank_addr, 8'h5B);
    ale_pulse(1'b1, 8'h67);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R10 write used old addr", bus_dout, 8'hAA);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule